// File: doc/BRIEF.md
# Serial-Address Byte ROM Port

This block gives a host processor access to a slow on-chip byte ROM through two memory-mapped locations. One location is write-only and takes the ROM address one byte at a time. The other location is read-only and returns the byte at the current ROM address. A host first sends two address bytes, most significant byte first. After that it reads the data location as often as it needs. Each read moves the internal address on by one, so a host can stream through a table without loading the address again.

Which address byte comes next is held in a one-bit phase register. No reset touches this register, so its value is unknown after power-up. A read of the data location always puts it back to "expecting the high byte". Software therefore does one throw-away read before it loads an address. The ROM is slow, so every accepted access stalls the host. The READY output is pulled low for a fixed number of clocks, and it is released one clock after the returned byte has settled on the data output.

Top module: `serial_rom_port`

## Requirements
- R1: While rst_ni is low and after it is released, ready_o is 1, data_o is 0x00 and the internal ROM address is 0x0000. Reset does not change the byte-phase register.
- R2: A cycle with rd_i high and addr_i equal to 0x9800, or wr_i high and addr_i equal to 0x9C02, while the port is idle, starts an access. ready_o then goes low at the next clock edge and stays low for exactly WAIT_CYC clocks (27 by default).
- R3: During a data read, data_o takes the ROM byte at the current address one clock before ready_o returns high. It then keeps that value until the next data read loads a new byte.
- R4: After each data read, the internal address goes up by one. 0xFFFF is followed by 0x0000.
- R5: An address-port write in the high-byte phase loads data_i into address bits 15:8 and moves to the low-byte phase. A write in the low-byte phase loads address bits 7:0 and returns to the high-byte phase. Writing 0x00 and then 0x20 therefore selects 0x0020.
- R6: A data read always leaves the phase register in the high-byte phase, whatever it held before.
- R7: The phase register keeps its value through reset, so a host that skips the throw-away read can load a misaligned address.
- R8: These accesses are ignored: rd_i at the address port, wr_i at the data port, and any strobe at another address. For them ready_o stays high and the address, phase and data_o do not change.
- R9: Keeping rd_i or wr_i high after ready_o has risen does not start a second access. The strobes must both be low for a clock before the next access is accepted.
- R10: The ROM byte at address A is (i*37 + (i>>8)*11 + 0x5A) mod 256, where i = A mod 1024 (ROM_AW = 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host bus address |
| data_i | input | 8 | Host write data (address bytes) |
| rd_i | input | 1 | Host read strobe, held until ready_o rises |
| wr_i | input | 1 | Host write strobe, held until ready_o rises |
| data_o | output | 8 | Byte returned by the last data read |
| ready_o | output | 1 | Low while an access is being stretched |

## Verification
The assertions assume that a host keeps its strobe and address steady from the cycle it raises the strobe until it sees ready_o high again, and that it drops the strobe after that. The address-increment and phase properties also assume that the host never raises rd_i and wr_i together for the same port. The bench keeps to these rules: it changes inputs only on falling clock edges, it holds each strobe until it sees ready_o high, and it always separates two accesses with at least one cycle in which both strobes are low. It drives misaligned phases on purpose, but only through the normal address port.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} srp_state_e;
  typedef enum logic {OP_RD, OP_WR} srp_op_e;

  function automatic logic [7:0] srp_rom_byte(input int unsigned idx);
    int unsigned v;
    v = idx * 37 + (idx >> 8) * 11 + 90;
    return v[7:0];
  endfunction
endpackage

// File: rtl/srp_timer.sv
module srp_timer
  import srp_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WAIT_CYC = 27,
  parameter logic [AW-1:0] RD_PORT = 16'h9800,
  parameter logic [AW-1:0] WR_PORT = 16'h9C02
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic          ready_o,
  output logic          start_o,
  output logic          load_o,
  output logic          commit_o,
  output srp_op_e       op_o
);
  localparam int unsigned CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;

  srp_state_e    state_q;
  logic [CW-1:0] cnt_q;
  srp_op_e       op_q;
  logic          req_rd, req_wr;

  assign req_rd  = rd_i && (addr_i == RD_PORT);
  assign req_wr  = wr_i && (addr_i == WR_PORT) && !req_rd;
  assign start_o = (state_q == ST_IDLE) && (req_rd || req_wr);
  assign load_o  = (state_q == ST_WAIT) && (cnt_q == CW'(1)) && (op_q == OP_RD);
  assign commit_o = (state_q == ST_WAIT) && (cnt_q == '0);
  assign op_o    = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_RD;
      ready_o <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_o) begin
          state_q <= ST_WAIT;
          cnt_q   <= CW'(WAIT_CYC - 1);
          op_q    <= req_rd ? OP_RD : OP_WR;
          ready_o <= 1'b0;
        end
        ST_WAIT: if (cnt_q == '0) begin
          state_q <= ST_HOLD;
          ready_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        ST_HOLD: if (!rd_i && !wr_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !ready_o); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (int'(cnt_q) < WAIT_CYC)); // R2
  AST_HOLD_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |=> ready_o); // R9
endmodule

// File: rtl/srp_addr.sv
module srp_addr
  import srp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        commit_i,
  input  srp_op_e     op_i,
  input  logic [7:0]  data_i,
  output logic [15:0] addr_o
);
  logic [7:0] wbyte_q;
  logic       lo_next_q; // no reset: undefined after power-up

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wbyte_q <= '0;
    end else begin
      if (start_i) wbyte_q <= data_i;
      if (commit_i) begin
        if (op_i == OP_RD)  addr_o <= addr_o + 16'd1;
        else if (!lo_next_q) addr_o[15:8] <= wbyte_q;
        else                 addr_o[7:0]  <= wbyte_q;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      if (op_i == OP_RD) lo_next_q <= 1'b0;
      else               lo_next_q <= !lo_next_q;
    end
  end

  AST_RD_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == OP_RD) |=> !lo_next_q); // R6
  AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(addr_o)); // R8
endmodule

// File: rtl/srp_rom.sv
module srp_rom
  import srp_pkg::*;
#(
  parameter int unsigned ROM_AW = 10
) (
  input  logic [ROM_AW-1:0] idx_i,
  output logic [7:0]        q_o
);
  localparam int unsigned DEPTH = 1 << ROM_AW;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign mem[g] = srp_rom_byte(g);
  end

  assign q_o = mem[idx_i];
endmodule

// File: rtl/serial_rom_port.sv
module serial_rom_port
  import srp_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 27,
  parameter int unsigned ROM_AW   = 10,
  parameter logic [15:0] RD_PORT  = 16'h9800,
  parameter logic [15:0] WR_PORT  = 16'h9C02
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        rd_i,
  input  logic        wr_i,
  output logic [7:0]  data_o,
  output logic        ready_o
);
  logic          start, load, commit;
  srp_op_e       op;
  logic [15:0]   addr_q;
  logic [ROM_AW-1:0] rom_idx;
  logic [7:0]    rom_q;

  srp_timer #(
    .AW(16), .WAIT_CYC(WAIT_CYC), .RD_PORT(RD_PORT), .WR_PORT(WR_PORT)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .ready_o(ready_o), .start_o(start), .load_o(load), .commit_o(commit), .op_o(op)
  );

  srp_addr u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .commit_i(commit),
    .op_i(op), .data_i(data_i), .addr_o(addr_q)
  );

  assign rom_idx = addr_q[ROM_AW-1:0];

  srp_rom #(.ROM_AW(ROM_AW)) u_rom (.idx_i(rom_idx), .q_o(rom_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (load) data_o <= rom_q;
  end

  AST_DATA_BEFORE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $stable(data_o)); // R3
  AST_ADDR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && op == OP_RD) |=> (addr_q == $past(addr_q) + 16'd1)); // R4
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start) |=> ready_o); // R8
endmodule

// File: tb/sim_serial_rom_port.sv
`timescale 1ns/1ps
module sim_serial_rom_port;
  localparam int unsigned WAIT_CYC = 27;
  localparam logic [15:0] RD_PORT = 16'h9800;
  localparam logic [15:0] WR_PORT = 16'h9C02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0]  data_o;
  logic        ready_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  logic [15:0] m_addr = '0;
  bit m_lo = 1'b0;

  always #2.5 clk = ~clk;

  serial_rom_port #(.WAIT_CYC(WAIT_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .rd_i(rd), .wr_i(wr), .data_o(data_o), .ready_o(ready_o)
  );

  function automatic logic [7:0] rom_val(input logic [15:0] a);
    int unsigned i, v;
    i = int'(a) % 1024;
    v = (i * 37 + (i / 256) * 11 + 90) % 256;
    return v[7:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: stall length and returned byte
  bit prev_rdy = 1'b1, cur_rd = 1'b0;
  int low_n = 0;
  logic [7:0] last_low = '0;
  always @(negedge clk) begin
    if (!ready_o) begin
      if (prev_rdy) begin low_n = 0; cur_rd = rd; end
      low_n++;
      last_low = data_o;
    end else if (!prev_rdy) begin
      check("R2 stall length", low_n, WAIT_CYC);
      if (cur_rd) begin
        if (exp_q.size() == 0) check("R3 unexpected read", 1, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check("R3/R10 read byte", data_o, e);
          check("R3 byte valid before ready", last_low, e);
        end
      end
    end
    prev_rdy = ready_o;
  end

  task automatic bus(input bit is_rd, input logic [15:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; din = d; rd = is_rd; wr = !is_rd;
    do @(negedge clk); while (!ready_o);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R9 held strobe no restart", ready_o, 1);
    end
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_byte(input int hold = 0);
    exp_q.push_back(rom_val(m_addr));
    m_addr++;
    m_lo = 1'b0;
    bus(1'b1, RD_PORT, 8'h00, hold);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    if (!m_lo) m_addr[15:8] = b; else m_addr[7:0] = b;
    m_lo = !m_lo;
    bus(1'b0, WR_PORT, b, 0);
  endtask

  task automatic ignored(input bit is_rd, input logic [15:0] a);
    @(negedge clk);
    addr = a; din = 8'hA5; rd = is_rd; wr = !is_rd;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 ignored access keeps ready", ready_o, 1);
    end
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 ready in reset", ready_o, 1);
    check("R1 data in reset", data_o, 0);
    @(negedge clk); rst_n = 1'b1;
    m_addr = '0; // R7: model phase kept
    @(negedge clk);
    check("R1 ready after reset", ready_o, 1);
    check("R1 data after reset", data_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", ready_o, 1);
    check("R1 data in reset", data_o, 0);
    rst_n = 1'b1;
    // R6: throw-away read resyncs an unknown phase; R1 address starts at 0
    rd_byte();
    // R5: MSB then LSB
    wr_byte(8'h00); wr_byte(8'h20);
    for (int k = 0; k < 4; k++) rd_byte(); // R4 R10
    // R8: wrong-direction and foreign accesses
    ignored(1'b1, WR_PORT); ignored(1'b0, RD_PORT);
    ignored(1'b1, 16'h1234); ignored(1'b0, 16'h0000);
    rd_byte(); // expects 0x0024: address untouched
    check("R8 data unchanged", data_o, rom_val(16'h0024));
    // R6: dangling first byte then a read clears phase
    wr_byte(8'h03); rd_byte();
    wr_byte(8'h01); wr_byte(8'h00); rd_byte();
    // R7: misaligned load without a resync read
    wr_byte(8'h00); wr_byte(8'h01); wr_byte(8'h40); rd_byte();
    // R4: wrap
    wr_byte(8'hFF); wr_byte(8'hFF); rd_byte(); rd_byte();
    check("R4 wrap address", m_addr, 16'h0001);
    // R9: strobe held after ready
    rd_byte(8); rd_byte();
    // R7: reset keeps a dangling phase; resync read then load
    wr_byte(8'h55);
    do_reset();
    rd_byte(); wr_byte(8'h00); wr_byte(8'h30); rd_byte(); rd_byte();
    // other starting phase
    do_reset();
    rd_byte(); wr_byte(8'h00); wr_byte(8'h30); rd_byte();
    repeat (4) @(negedge clk);
    check("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule